// File: doc/BRIEF.md
# UART Receive Byte Queue with Trigger and Timeout

This block holds received bytes for a serial port until software reads them. It accepts one byte per clock. The byte comes from the line side, from a line-break event, or from the transmit data register when the port is looped back internally. Bytes leave in arrival order through a data-register read strobe. The queue drives three status levels (empty, full, trigger reached) and two single-cycle event pulses (overrun, receive timeout). An interrupt unit downstream consumes the levels and the pulses.

A small control word enables the queue, disables it, and resets it. While the queue is not enabled, pushes and reads have no effect. The trigger level is programmable. The timeout restarts on every accepted byte and fires after four character times of silence. Software supplies the character time as a number of clock cycles.

Top module: `rxq_top`

## Requirements
- R1: The queue holds up to 16 bytes and returns them in arrival order. An accepted read strobe places the oldest byte on `rd_data` one clock later.
- R2: Pushes and reads take effect only while control bit 2 (enable) is set and control bit 3 (disable) is clear. A control write takes effect on the following cycle. After reset the enable bit is 0 and the disable bit is 1. A read while the queue is not enabled leaves the stored bytes untouched and drives `rd_data` to 0.
- R3: An accepted push while 16 bytes are held discards the byte and pulses `ev_ovr` high for one cycle. The count stays at 16.
- R4: `st_full` rises when an accepted push brings the count to 16. Any accepted read clears it.
- R5: `st_trig` rises when an accepted push leaves the count at or above the trigger level. It falls when an accepted read leaves the count below that level. The trigger level resets to 32, so `st_trig` cannot rise until software lowers it.
- R6: `st_empty` is 1 after reset. Any accepted push clears it. A read that leaves the queue empty sets it. A read while empty returns 0 and sets it.
- R7: Each push that stores a byte reloads a countdown of 4 × `char_ticks` cycles. When the countdown runs out, `ev_tmo` pulses high for one cycle. The pulse comes 4 × `char_ticks` clocks after the edge that stored the byte. A `char_ticks` of 0 disables the timeout.
- R8: Writing control bit 0 as 1 empties the queue at once. The reset is self-clearing. It sets `st_empty`, clears `st_full`, clears `st_trig` and cancels a pending timeout.
- R9: `chmode` selects the source of bytes. In 0 (normal) and 1 (echo), line bytes enter and transmit-register writes do not. In 2 (local loopback), transmit-register writes enter and line bytes do not. In 3 (remote loopback), neither enters.
- R10: A line-break strobe pushes a zero byte in every channel mode. If several sources strobe in the same cycle, the break wins over a line byte, and a line byte wins over a transmit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word: bit 0 queue reset, bit 2 enable, bit 3 disable |
| trig_wr | input | 1 | Trigger level write strobe |
| trig_wdata | input | 6 | New trigger level |
| chmode | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| line_vld | input | 1 | Received byte strobe from the line side |
| line_byte | input | 8 | Received byte |
| line_brk | input | 1 | Line-break event strobe |
| txd_wr | input | 1 | Transmit data register write strobe |
| txd_byte | input | 8 | Transmit data register write value |
| rd_stb | input | 1 | Data register read strobe |
| char_ticks | input | 16 | Clock cycles per character time |
| rd_data | output | 8 | Byte returned by the last read |
| st_empty | output | 1 | Queue empty level |
| st_full | output | 1 | Queue full level |
| st_trig | output | 1 | Trigger level reached |
| ev_ovr | output | 1 | Overrun pulse |
| ev_tmo | output | 1 | Receive timeout pulse |

## Verification
A vector walk with a trigger level of 3 interleaves line pushes, break pushes and reads. It shows that the flags follow the set and clear rules rather than tracking the count directly: `st_trig` falls only after a read and rises again only after a push. Filling the queue to capacity and then pushing once more separates a discarded byte from an overwritten one, because the 16 bytes read back must all be the originals. Each channel mode gets one byte from each source, which shows which path is routed into the queue. Two timeout runs, one with a mid-count restart, show whether the countdown reloads or keeps running.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LLOOP  = 2'd2,
        CH_RLOOP  = 2'd3
    } chmode_e;

    localparam int CTL_W   = 4;
    localparam int CTL_RST = 0;
    localparam int CTL_EN  = 2;
    localparam int CTL_DIS = 3;
endpackage

// File: rtl/rxq_src.sv
module rxq_src
    import rxq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [1:0]    chmode,
    input  logic          line_vld,
    input  logic [DW-1:0] line_byte,
    input  logic          line_brk,
    input  logic          txd_wr,
    input  logic [DW-1:0] txd_byte,
    output logic          push,
    output logic [DW-1:0] push_byte
);
    chmode_e mode;
    logic    line_path;
    logic    txd_path;

    always_comb begin
        mode      = chmode_e'(chmode);
        line_path = (mode == CH_NORMAL) || (mode == CH_ECHO);
        txd_path  = (mode == CH_LLOOP);
        push      = 1'b0;
        push_byte = '0;
        if (line_brk) begin
            push = 1'b1;
        end else if (line_vld && line_path) begin
            push      = 1'b1;
            push_byte = line_byte;
        end else if (txd_wr && txd_path) begin
            push      = 1'b1;
            push_byte = txd_byte;
        end
    end
endmodule

// File: rtl/rxq_tmo.sv
module rxq_tmo #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              clr,
    input  logic [TICK_W-1:0] char_ticks,
    output logic              ev_tmo
);
    localparam int TW = TICK_W + 2;

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          ev;
    } tmo_st_t;

    tmo_st_t q, d;

    always_comb begin
        d    = q;
        d.ev = 1'b0;
        if (clr) begin
            d.tmr = '0;
        end else if (restart) begin
            d.tmr = {char_ticks, 2'b00};
        end else if (q.tmr != '0) begin
            d.tmr = q.tmr - TW'(1);
            d.ev  = (q.tmr == TW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.tmr <= '0;
            q.ev  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ev_tmo = q.ev;

    // R7: the timeout is a single-cycle pulse
    p_tmo_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.ev |=> !q.ev);
    // R7: a nonzero reload keeps the countdown armed on the next cycle
    p_tmo_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !clr && char_ticks != '0) |=> (q.tmr != '0 && !q.ev));
endmodule

// File: rtl/rxq_core.sv
module rxq_core
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    parameter int TRIG_W   = 6,
    parameter int TRIG_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              trig_wr,
    input  logic [TRIG_W-1:0] trig_wdata,
    input  logic              push,
    input  logic [DW-1:0]     push_byte,
    input  logic              rd_stb,
    output logic [DW-1:0]     rd_data,
    output logic              st_empty,
    output logic              st_full,
    output logic              st_trig,
    output logic              ev_ovr,
    output logic              stored,
    output logic              rxrst
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = AW + 1;
    localparam int CMPW = (CW > TRIG_W) ? CW : TRIG_W;

    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [CW-1:0]     cnt;
        logic [TRIG_W-1:0] lvl;
        logic              en;
        logic              dis;
        logic              empty;
        logic              full;
        logic              trig;
        logic              ovr;
        logic [DW-1:0]     rdat;
    } core_st_t;

    core_st_t q, d;
    logic [DW-1:0] mem [DEPTH];

    logic          active, is_full, push_acc, push_ok, pop_acc, pop_ok;
    logic [AW-1:0] rptr;
    logic          unused_ctl;

    assign unused_ctl = ctl_wdata[1];

    always_comb begin
        active   = q.en && !q.dis;
        rxrst    = ctl_wr && ctl_wdata[CTL_RST];
        is_full  = (q.cnt == CW'(DEPTH));
        push_acc = push && active;
        push_ok  = push_acc && !is_full;
        pop_acc  = rd_stb && active;
        pop_ok   = pop_acc && (q.cnt != '0);
        rptr     = q.wptr - q.cnt[AW-1:0];

        d     = q;
        d.ovr = push_acc && is_full;
        if (ctl_wr) begin
            d.en  = ctl_wdata[CTL_EN];
            d.dis = ctl_wdata[CTL_DIS];
        end
        if (trig_wr) begin
            d.lvl = trig_wdata;
        end
        if (rd_stb) begin
            d.rdat = pop_ok ? mem[rptr] : '0;
        end
        d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
        if (push_ok) begin
            d.wptr = q.wptr + AW'(1);
        end

        if (push_acc) begin
            d.empty = 1'b0;
        end else if (pop_acc && d.cnt == '0) begin
            d.empty = 1'b1;
        end

        if (pop_acc) begin
            d.full = 1'b0;
        end else if (push_ok && d.cnt == CW'(DEPTH)) begin
            d.full = 1'b1;
        end

        if (push_ok && CMPW'(d.cnt) >= CMPW'(q.lvl)) begin
            d.trig = 1'b1;
        end else if (pop_acc && CMPW'(d.cnt) < CMPW'(q.lvl)) begin
            d.trig = 1'b0;
        end

        if (rxrst) begin
            d.wptr  = '0;
            d.cnt   = '0;
            d.empty = 1'b1;
            d.full  = 1'b0;
            d.trig  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.wptr  <= '0;
            q.cnt   <= '0;
            q.lvl   <= TRIG_W'(TRIG_RST);
            q.en    <= 1'b0;
            q.dis   <= 1'b1;
            q.empty <= 1'b1;
            q.full  <= 1'b0;
            q.trig  <= 1'b0;
            q.ovr   <= 1'b0;
            q.rdat  <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !rxrst) begin
            mem[q.wptr] <= push_byte;
        end
    end

    assign stored   = push_ok && !rxrst;
    assign rd_data  = q.rdat;
    assign st_empty = q.empty;
    assign st_full  = q.full;
    assign st_trig  = q.trig;
    assign ev_ovr   = q.ovr;

    // R3: the count never exceeds the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    // R3: a push into a full queue leaves it full when nothing is read
    p_ovr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && active && is_full && !rd_stb && !rxrst) |=> (q.cnt == CW'(DEPTH) && q.ovr));
    // R4: an accepted read clears full
    p_full_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_acc |=> !q.full);
    // R6: an accepted push clears empty
    p_empty_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_acc && !rxrst) |=> !q.empty);
    // R2: a queue that is not enabled keeps its count
    p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !rxrst) |=> $stable(q.cnt));
    // R8: the receive reset empties the queue
    p_rxrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rxrst |=> (q.cnt == '0 && q.empty && !q.full && !q.trig));
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    parameter int TRIG_W   = 6,
    parameter int TRIG_RST = 32,
    parameter int TICK_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              trig_wr,
    input  logic [TRIG_W-1:0] trig_wdata,
    input  logic [1:0]        chmode,
    input  logic              line_vld,
    input  logic [DW-1:0]     line_byte,
    input  logic              line_brk,
    input  logic              txd_wr,
    input  logic [DW-1:0]     txd_byte,
    input  logic              rd_stb,
    input  logic [TICK_W-1:0] char_ticks,
    output logic [DW-1:0]     rd_data,
    output logic              st_empty,
    output logic              st_full,
    output logic              st_trig,
    output logic              ev_ovr,
    output logic              ev_tmo
);
    logic          push;
    logic [DW-1:0] push_byte;
    logic          stored;
    logic          rxrst;

    rxq_src #(.DW(DW)) u_src (
        .chmode    (chmode),
        .line_vld  (line_vld),
        .line_byte (line_byte),
        .line_brk  (line_brk),
        .txd_wr    (txd_wr),
        .txd_byte  (txd_byte),
        .push      (push),
        .push_byte (push_byte)
    );

    rxq_core #(
        .DEPTH(DEPTH), .DW(DW), .TRIG_W(TRIG_W), .TRIG_RST(TRIG_RST)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .trig_wr    (trig_wr),
        .trig_wdata (trig_wdata),
        .push       (push),
        .push_byte  (push_byte),
        .rd_stb     (rd_stb),
        .rd_data    (rd_data),
        .st_empty   (st_empty),
        .st_full    (st_full),
        .st_trig    (st_trig),
        .ev_ovr     (ev_ovr),
        .stored     (stored),
        .rxrst      (rxrst)
    );

    rxq_tmo #(.TICK_W(TICK_W)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (stored),
        .clr        (rxrst),
        .char_ticks (char_ticks),
        .ev_tmo     (ev_tmo)
    );
endmodule

// File: tb/tb_rxq_top.sv
module tb_rxq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [3:0]  ctl_wdata = '0;
    logic        trig_wr = 1'b0;
    logic [5:0]  trig_wdata = '0;
    logic [1:0]  chmode = 2'd0;
    logic        line_vld = 1'b0;
    logic [7:0]  line_byte = '0;
    logic        line_brk = 1'b0;
    logic        txd_wr = 1'b0;
    logic [7:0]  txd_byte = '0;
    logic        rd_stb = 1'b0;
    logic [15:0] char_ticks = '0;
    logic [7:0]  rd_data;
    logic        st_empty, st_full, st_trig, ev_ovr, ev_tmo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [3:0] C_ON  = 4'b0100;
    localparam logic [3:0] C_OFF = 4'b1000;
    localparam logic [3:0] C_RST = 4'b0101;

    // op: 0 line push, 1 read, 3 break ; data ; expected read data ; empty full trig
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {2'd0, 8'hA1, 8'h00, 3'b000},
        {2'd0, 8'hB2, 8'h00, 3'b000},
        {2'd0, 8'hC3, 8'h00, 3'b001},
        {2'd1, 8'h00, 8'hA1, 3'b000},
        {2'd0, 8'hD4, 8'h00, 3'b001},
        {2'd3, 8'h00, 8'h00, 3'b001},
        {2'd1, 8'h00, 8'hB2, 3'b001},
        {2'd1, 8'h00, 8'hC3, 3'b000},
        {2'd1, 8'h00, 8'hD4, 3'b000},
        {2'd1, 8'h00, 8'h00, 3'b100},
        {2'd1, 8'h00, 8'h00, 3'b100},
        {2'd0, 8'h5A, 8'h00, 3'b000},
        {2'd1, 8'h00, 8'h5A, 3'b100}
    };

    rxq_top dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .trig_wr(trig_wr), .trig_wdata(trig_wdata), .chmode(chmode),
        .line_vld(line_vld), .line_byte(line_byte), .line_brk(line_brk),
        .txd_wr(txd_wr), .txd_byte(txd_byte), .rd_stb(rd_stb),
        .char_ticks(char_ticks), .rd_data(rd_data), .st_empty(st_empty),
        .st_full(st_full), .st_trig(st_trig), .ev_ovr(ev_ovr), .ev_tmo(ev_tmo)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0; trig_wr = 1'b0; line_vld = 1'b0;
        line_brk = 1'b0; txd_wr = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic ctl(input logic [3:0] w);
        ctl_wr = 1'b1; ctl_wdata = w; step();
    endtask
    task automatic settrig(input logic [5:0] v);
        trig_wr = 1'b1; trig_wdata = v; step();
    endtask
    task automatic pline(input logic [7:0] b);
        line_vld = 1'b1; line_byte = b; step();
    endtask
    task automatic ptxd(input logic [7:0] b);
        txd_wr = 1'b1; txd_byte = b; step();
    endtask
    task automatic pbrk();
        line_brk = 1'b1; step();
    endtask
    task automatic rd();
        rd_stb = 1'b1; step();
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R6 empty after reset", st_empty, 1);
        chk("R4 full after reset", st_full, 0);
        chk("R5 trig after reset", st_trig, 0);
        chk("R3 ovr after reset", ev_ovr, 0);
        chk("R1 rd_data after reset", rd_data, 0);

        // R2: disabled after reset, pushes ignored
        pline(8'h77);
        chk("R2 push ignored while disabled", st_empty, 1);
        ctl(C_ON);
        rd();
        chk("R2 disabled push left nothing", rd_data, 0);
        pline(8'h42);
        ctl(C_OFF);
        rd();
        chk("R2 read while disabled gives 0", rd_data, 0);
        chk("R2 read while disabled keeps byte", st_empty, 0);
        ctl(C_ON);
        rd();
        chk("R2 byte survived disabled read", rd_data, 8'h42);

        // R3 R4 R5: fill with default trigger 32
        for (int i = 0; i < 16; i++) pline(8'(8'h10 + i));
        chk("R4 full at 16", st_full, 1);
        chk("R5 trig stays low with reset level 32", st_trig, 0);
        pline(8'hEE);
        chk("R3 overrun pulse", ev_ovr, 1);
        step();
        chk("R3 overrun pulse one cycle", ev_ovr, 0);
        for (int i = 0; i < 16; i++) begin
            rd();
            chk("R1 R3 in-order data, overrun byte discarded", rd_data, 8'(8'h10 + i));
            if (i == 0) chk("R4 full cleared by read", st_full, 0);
        end
        chk("R6 empty after draining", st_empty, 1);

        // vector walk, trigger level 3
        settrig(6'd3);
        for (int v = 0; v < NV; v++) begin
            case (VEC[v][20:19])
                2'd0: pline(VEC[v][18:11]);
                2'd1: rd();
                default: pbrk();
            endcase
            if (VEC[v][20:19] == 2'd1) chk("R1 R10 vector read data", rd_data, VEC[v][10:3]);
            chk("R6 vector empty", st_empty, VEC[v][2]);
            chk("R4 vector full", st_full, VEC[v][1]);
            chk("R5 vector trig", st_trig, VEC[v][0]);
        end

        // R8 receive reset
        pline(8'h01); pline(8'h02); pline(8'h03);
        chk("R5 trig before reset", st_trig, 1);
        ctl(C_RST);
        chk("R8 empty after queue reset", st_empty, 1);
        chk("R8 trig cleared by queue reset", st_trig, 0);
        rd();
        chk("R8 queue reset discards bytes", rd_data, 0);

        // R9 routing
        chmode = 2'd2;
        pline(8'h31); ptxd(8'h32);
        rd(); chk("R9 local loopback takes txd", rd_data, 8'h32);
        rd(); chk("R9 local loopback drops line byte", rd_data, 0);
        chmode = 2'd3;
        pline(8'h41); ptxd(8'h42);
        chk("R9 remote loopback enters nothing", st_empty, 1);
        pbrk();
        chk("R10 break pushes in remote loopback", st_empty, 0);
        rd(); chk("R10 break byte is zero", rd_data, 0);
        chmode = 2'd1;
        ptxd(8'h51); pline(8'h52);
        rd(); chk("R9 echo takes line byte only", rd_data, 8'h52);
        chmode = 2'd0;
        ptxd(8'h61);
        chk("R9 normal drops txd", st_empty, 1);
        line_vld = 1'b1; line_byte = 8'h71; line_brk = 1'b1; step();
        line_vld = 1'b1; line_byte = 8'h72; txd_wr = 1'b1; txd_byte = 8'h73; step();
        rd(); chk("R10 break wins over line byte", rd_data, 0);
        rd(); chk("R10 line byte wins over txd", rd_data, 8'h72);
        chk("R10 single push per cycle", st_empty, 1);

        // R7 timeout: 4 * 5 = 20 cycles
        char_ticks = 16'd5;
        begin
            bit early;
            early = 1'b0;
            pline(8'h81);
            for (int i = 0; i < 19; i++) begin
                if (ev_tmo) early = 1'b1;
                step();
            end
            chk("R7 no timeout before four char times", {31'd0, early | ev_tmo}, 0);
            step();
            chk("R7 timeout after four char times", ev_tmo, 1);
            step();
            chk("R7 timeout is one pulse", ev_tmo, 0);

            early = 1'b0;
            pline(8'h82);
            for (int i = 0; i < 10; i++) step();
            pline(8'h83);
            for (int i = 0; i < 19; i++) begin
                if (ev_tmo) early = 1'b1;
                step();
            end
            chk("R7 push restarts timeout", {31'd0, early | ev_tmo}, 0);
            step();
            chk("R7 restarted timeout fires", ev_tmo, 1);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule